// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers eighteen interrupt request lines and presents one of them at a time to a processor core. Each line sets a sticky pending flag. A flag only competes for service when its own enable bit and a global enable are both set. The lines are organised into six groups of three, and each group is given one of four priority levels by a two-bit field. The controller picks the winning pending source and shows its index and level together with a request strobe.

The core answers with an acknowledge pulse. The acknowledge clears the winner's pending flag, unless that source is marked level-held, and pushes its level onto a four-entry nesting stack. A return pulse pops the stack. While a routine is in service, only a request at a strictly higher level is shown. The block also drives two wake outputs. One brings an idle core back to active whenever any enabled request is pending. The other wakes the core from a deeper sleep, and only the sources selected in a sleep mask can drive it.

Top module: `irq_group_ctrl`

## Requirements
- R1: While reset is asserted, the pending flags are 0, `irq_req` is 0, the nesting depth is 0, and both wake outputs are 0.
- R2: A source line that is high at a clock edge sets its pending flag at that edge. The flag then stays set after the line falls.
- R3: A bit of `clr_mask` that is high at a clock edge clears that source's pending flag, unless the source line is high at the same edge, in which case the set wins.
- R4: A pending source takes part in selection only when `glob_en` and its `src_en` bit are both 1. A disabled source keeps its pending flag, which stays visible on `pend_out`.
- R5: Group g holds sources g, g+6 and g+12. Its level is `grp_lvl[2g+1:2g]`, where 3 is the highest level and 0 the lowest. Among the enabled pending sources, one with the highest group level is chosen.
- R6: When the highest level is shared, the lower-numbered group wins. Inside a group, the lower-numbered source wins.
- R7: `ack` while `irq_req` is 1 clears the pending flag of `irq_vec` at that edge, pushes `irq_lvl` onto the stack, and raises `depth_out` by one.
- R8: A source whose `held_cfg` bit is 1 keeps its pending flag when it is acknowledged.
- R9: While `depth_out` is nonzero, `irq_req` is 1 only if the winning level is strictly above the level on top of the stack. The stack holds up to four entries.
- R10: `reti` pops one stack entry and has no effect at depth 0. An `ack` in the same cycle as `reti` is ignored.
- R11: `wake_active` is 1 exactly when `idle_mode` is 1, `glob_en` is 1, and any enabled source is pending.
- R12: `sleep_wake` is 1 exactly when `glob_en` is 1 and some source is pending, enabled, and selected in `sleep_mask`. This holds whatever the value of `idle_mode`.
- R13: `irq_vec` is the winning source's index (0 to 17), and `irq_lvl` is its group's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 18 | Interrupt request lines |
| src_en | input | 18 | Per-source enable |
| held_cfg | input | 18 | Level-held marking, flag survives acknowledge |
| sleep_mask | input | 18 | Sources allowed to drive the sleep wake |
| clr_mask | input | 18 | Software clear of pending flags |
| grp_lvl | input | 12 | Two-bit level per group |
| glob_en | input | 1 | Global interrupt enable |
| idle_mode | input | 1 | Core is idle |
| ack | input | 1 | Core accepts the shown vector |
| reti | input | 1 | Core returns from the routine in service |
| irq_req | output | 1 | Request strobe to the core |
| irq_vec | output | 5 | Winning source index |
| irq_lvl | output | 2 | Winning level |
| pend_out | output | 18 | Pending flags |
| depth_out | output | 3 | Current nesting depth |
| wake_active | output | 1 | Idle-to-active wake |
| sleep_wake | output | 1 | Deep-sleep wake |

## Verification
The hardest state to reach from the ports is a deep nesting stack whose top level is below a later pending request. Reaching it needs requests raised one at a time with rising group levels, each acknowledged before the next one arrives. The bench builds the stack step by step in this way. It raises the group level of an already pending source while that source is held back, then unwinds with return pulses and checks that the held-back source reappears once the blocking level is popped. An acknowledge that coincides with a return, and a return at depth zero, are driven on purpose.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int IRQ_NSRC  = 18;
  localparam int IRQ_NGRP  = 6;
  localparam int IRQ_LVLW  = 2;
  localparam int IRQ_DEPTH = 4;
  localparam int IRQ_RSTG  = 2;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 18,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] clr_mask,
  input  logic [N_SRC-1:0] held_cfg,
  input  logic             ack_fire,
  input  logic [VEC_W-1:0] ack_vec,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] pend_q, pend_n, ack_hit;
  logic             upd_en;

  always_comb begin
    ack_hit = '0;
    if (ack_fire) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (VEC_W'(i) == ack_vec) ack_hit[i] = ~held_cfg[i];
      end
    end
    pend_n = (pend_q & ~clr_mask & ~ack_hit) | src_req;
    upd_en = ack_fire | (|src_req) | (|clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_n;
  end

  assign pend = pend_q;

  p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req) |=> ((pend_q & $past(src_req)) == $past(src_req)));

  p_sw_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((pend_q & $past(clr_mask & ~src_req)) == '0));

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !held_cfg[ack_vec] && !src_req[ack_vec]) |=> !pend_q[$past(ack_vec)]);

  p_held_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && held_cfg[ack_vec] && pend_q[ack_vec] && !clr_mask[ack_vec])
      |=> pend_q[$past(ack_vec)]);
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int N_SRC = 18,
  parameter int N_GRP = 6,
  parameter int LVL_W = 2,
  localparam int VEC_W = $clog2(N_SRC),
  localparam int SPG   = N_SRC / N_GRP
) (
  input  logic [N_SRC-1:0]       active,
  input  logic [N_GRP*LVL_W-1:0] grp_lvl,
  output logic                   found,
  output logic [VEC_W-1:0]       best_vec,
  output logic [LVL_W-1:0]       best_lvl
);
  logic [N_GRP-1:0] grp_hit;
  logic [VEC_W-1:0] grp_src [N_GRP];

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic             hit_l;
    logic [VEC_W-1:0] src_l;
    always_comb begin
      hit_l = 1'b0;
      src_l = '0;
      for (int k = SPG - 1; k >= 0; k--) begin
        if (active[g + k*N_GRP]) begin
          hit_l = 1'b1;
          src_l = VEC_W'(g + k*N_GRP);
        end
      end
    end
    assign grp_hit[g] = hit_l;
    assign grp_src[g] = src_l;
  end

  always_comb begin
    found    = 1'b0;
    best_vec = '0;
    best_lvl = '0;
    for (int g = N_GRP - 1; g >= 0; g--) begin
      if (grp_hit[g] && (!found || grp_lvl[g*LVL_W +: LVL_W] >= best_lvl)) begin
        found    = 1'b1;
        best_vec = grp_src[g];
        best_lvl = grp_lvl[g*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 2,
  localparam int DEP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] push_lvl,
  output logic [DEP_W-1:0] depth,
  output logic [LVL_W-1:0] top_lvl
);
  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [LVL_W-1:0] stk_n [DEPTH];
  logic [DEP_W-1:0] depth_q, depth_n;
  logic             upd_en;

  always_comb begin
    depth_n = depth_q;
    stk_n   = stk_q;
    upd_en  = push | pop;
    if (pop) begin
      if (depth_q != '0) depth_n = depth_q - 1'b1;
    end else if (push && depth_q < DEP_W'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (DEP_W'(i) == depth_q) stk_n[i] = push_lvl;
      end
      depth_n = depth_q + 1'b1;
    end
  end

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (DEP_W'(i + 1) == depth_q) top_lvl = stk_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (upd_en) begin
      depth_q <= depth_n;
      stk_q   <= stk_n;
    end
  end

  assign depth = depth_q;

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEP_W'(DEPTH));

  p_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && depth_q != '0) |-> (push_lvl > top_lvl));

  p_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (depth_q == $past(depth_q) + 1'b1));

  p_pop_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && depth_q == '0) |=> (depth_q == '0));
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_grp_pkg::*;
#(
  parameter int N_SRC = IRQ_NSRC,
  parameter int N_GRP = IRQ_NGRP,
  parameter int LVL_W = IRQ_LVLW,
  parameter int DEPTH = IRQ_DEPTH,
  parameter int RSTG  = IRQ_RSTG
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_SRC-1:0]            src_req,
  input  logic [N_SRC-1:0]            src_en,
  input  logic [N_SRC-1:0]            held_cfg,
  input  logic [N_SRC-1:0]            sleep_mask,
  input  logic [N_SRC-1:0]            clr_mask,
  input  logic [N_GRP*LVL_W-1:0]      grp_lvl,
  input  logic                        glob_en,
  input  logic                        idle_mode,
  input  logic                        ack,
  input  logic                        reti,
  output logic                        irq_req,
  output logic [$clog2(N_SRC)-1:0]    irq_vec,
  output logic [LVL_W-1:0]            irq_lvl,
  output logic [N_SRC-1:0]            pend_out,
  output logic [$clog2(DEPTH+1)-1:0]  depth_out,
  output logic                        wake_active,
  output logic                        sleep_wake
);
  localparam int VEC_W = $clog2(N_SRC);
  localparam int DEP_W = $clog2(DEPTH + 1);

  logic [RSTG-1:0]  rst_pipe;
  logic             rst_n_s;
  logic [N_SRC-1:0] pend, active;
  logic             found, ack_fire;
  logic [VEC_W-1:0] best_vec;
  logic [LVL_W-1:0] best_lvl, top_lvl;
  logic [DEP_W-1:0] depth;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RSTG-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[RSTG-1];

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n_s), .src_req(src_req), .clr_mask(clr_mask),
    .held_cfg(held_cfg), .ack_fire(ack_fire), .ack_vec(best_vec), .pend(pend)
  );

  always_comb begin
    active   = pend & src_en & {N_SRC{glob_en}};
    irq_req  = found && (depth == '0 || best_lvl > top_lvl);
    ack_fire = ack && irq_req && !reti;
  end

  irq_prio_resolve #(.N_SRC(N_SRC), .N_GRP(N_GRP), .LVL_W(LVL_W)) u_res (
    .active(active), .grp_lvl(grp_lvl), .found(found),
    .best_vec(best_vec), .best_lvl(best_lvl)
  );

  irq_nest_stack #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_stk (
    .clk(clk), .rst_n(rst_n_s), .push(ack_fire), .pop(reti),
    .push_lvl(best_lvl), .depth(depth), .top_lvl(top_lvl)
  );

  assign irq_vec     = best_vec;
  assign irq_lvl     = best_lvl;
  assign pend_out    = pend;
  assign depth_out   = depth;
  assign wake_active = idle_mode && (|active);
  assign sleep_wake  = glob_en && (|(pend & src_en & sleep_mask));

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> (glob_en && src_en[irq_vec] && pend_out[irq_vec]));

  p_lvl_match_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> (irq_lvl == grp_lvl[(int'(irq_vec) % N_GRP)*LVL_W +: LVL_W]));

  p_vec_range_r13: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> (int'(irq_vec) < N_SRC));

  p_sleep_src_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    sleep_wake |-> (|(pend_out & sleep_mask)));
endmodule

// File: tb/tb_irq_group_ctrl.sv
module tb_irq_group_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] src_req, src_en, held_cfg, sleep_mask, clr_mask;
  logic [11:0] grp_lvl;
  logic        glob_en, idle_mode, ack, reti;
  logic        irq_req, wake_active, sleep_wake;
  logic [4:0]  irq_vec;
  logic [1:0]  irq_lvl;
  logic [17:0] pend_out;
  logic [2:0]  depth_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_group_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .held_cfg(held_cfg), .sleep_mask(sleep_mask), .clr_mask(clr_mask),
    .grp_lvl(grp_lvl), .glob_en(glob_en), .idle_mode(idle_mode),
    .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_lvl(irq_lvl), .pend_out(pend_out), .depth_out(depth_out),
    .wake_active(wake_active), .sleep_wake(sleep_wake)
  );

  // {req[18], en[18], lvl[12], exp_valid, exp_vec[5], exp_lvl[2]}
  localparam logic [55:0] VT [9] = '{
    {18'h00020, 18'h3FFFF, 12'h000, 1'b1, 5'd5,  2'd0},
    {18'h04004, 18'h3FFFF, 12'h000, 1'b1, 5'd2,  2'd0},
    {18'h00012, 18'h3FFFF, 12'h200, 1'b1, 5'd4,  2'd2},
    {18'h00009, 18'h3FFFF, 12'h041, 1'b1, 5'd0,  2'd1},
    {18'h01080, 18'h3FFFF, 12'h000, 1'b1, 5'd12, 2'd0},
    {18'h20800, 18'h3F7FF, 12'hC00, 1'b1, 5'd17, 2'd3},
    {18'h00200, 18'h3FDFF, 12'h000, 1'b0, 5'd0,  2'd0},
    {18'h12000, 18'h3FFFF, 12'h30C, 1'b1, 5'd13, 2'd3},
    {18'h20820, 18'h3FFFF, 12'h400, 1'b1, 5'd5,  2'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    clr_mask = '1;
    src_req  = '0;
    step();
    clr_mask = '0;
    #1;
  endtask

  task automatic pulse(input logic [17:0] m);
    src_req = m;
    step();
    src_req = '0;
    #1;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
    #1;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    step();
    reti = 1'b0;
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [17:0] t_req, t_en;
    logic [11:0] t_lvl;
    logic        t_v;
    logic [4:0]  t_vec;
    logic [1:0]  t_l;
    rst_n = 1'b0;
    src_req = '0; src_en = '1; held_cfg = '0; sleep_mask = '1; clr_mask = '0;
    grp_lvl = '0; glob_en = 1'b1; idle_mode = 1'b1; ack = 1'b0; reti = 1'b0;
    step(); step();
    chk("R1 irq_req", irq_req, 0);
    chk("R1 pend", pend_out, 0);
    chk("R1 depth", depth_out, 0);
    chk("R1 wake_active", wake_active, 0);
    chk("R1 sleep_wake", sleep_wake, 0);
    rst_n = 1'b1;
    idle_mode = 1'b0; sleep_mask = '0;
    step(); step(); step();

    for (int i = 0; i < 9; i++) begin
      {t_req, t_en, t_lvl, t_v, t_vec, t_l} = VT[i];
      src_en  = t_en;
      grp_lvl = t_lvl;
      clear_all();
      pulse(t_req);
      chk("R2 pend set", pend_out, t_req);
      chk("R6 req valid", irq_req, t_v);
      if (t_v) begin
        chk("R5 vec", irq_vec, t_vec);
        chk("R13 lvl", irq_lvl, t_l);
      end
    end

    src_en = '1; grp_lvl = '0;
    clear_all();
    glob_en = 1'b0; idle_mode = 1'b1;
    pulse(18'h00008);
    chk("R4 global off irq_req", irq_req, 0);
    chk("R4 pend kept", pend_out[3], 1);
    chk("R11 wake gated", wake_active, 0);
    glob_en = 1'b1; #1;
    chk("R4 global on irq_req", irq_req, 1);
    chk("R13 vec", irq_vec, 3);
    chk("R11 wake idle", wake_active, 1);
    idle_mode = 1'b0; #1;
    chk("R11 wake not idle", wake_active, 0);
    sleep_mask = 18'h00008; #1;
    chk("R12 sleep selected", sleep_wake, 1);
    sleep_mask = 18'h00010; #1;
    chk("R12 sleep unselected", sleep_wake, 0);
    sleep_mask = '0;

    clr_mask = 18'h00008; step(); clr_mask = '0; #1;
    chk("R3 cleared", pend_out[3], 0);
    chk("R3 no request", irq_req, 0);
    src_req = 18'h00008; clr_mask = 18'h00008; step();
    src_req = '0; clr_mask = '0; #1;
    chk("R3 set wins", pend_out[3], 1);

    clear_all();
    pulse(18'h00008);
    do_ack();
    chk("R7 depth", depth_out, 1);
    chk("R7 pend cleared", pend_out[3], 0);
    chk("R7 req drops", irq_req, 0);

    pulse(18'h00010);
    chk("R9 equal level blocked", irq_req, 0);
    chk("R9 pend", pend_out[4], 1);
    grp_lvl = 12'h200; #1;
    chk("R9 higher level shown", irq_req, 1);
    chk("R9 vec", irq_vec, 4);
    do_ack();
    chk("R9 depth two", depth_out, 2);
    chk("R9 no req", irq_req, 0);
    grp_lvl = 12'h210;
    pulse(18'h00004);
    chk("R9 lower blocked", irq_req, 0);
    do_reti();
    chk("R10 pop depth", depth_out, 1);
    chk("R10 unblocked", irq_req, 1);
    chk("R10 vec", irq_vec, 2);
    chk("R13 lvl", irq_lvl, 1);
    do_reti();
    chk("R10 depth zero", depth_out, 0);
    do_reti();
    chk("R10 floor", depth_out, 0);
    ack = 1'b1; reti = 1'b1; step(); ack = 1'b0; reti = 1'b0; #1;
    chk("R10 ack with reti depth", depth_out, 0);
    chk("R10 ack with reti pend", pend_out[2], 1);
    do_ack();
    chk("R7 depth after ack", depth_out, 1);
    chk("R7 pend2 cleared", pend_out[2], 0);
    do_reti();

    clear_all();
    held_cfg = 18'h00040;
    pulse(18'h00040);
    do_ack();
    chk("R8 depth", depth_out, 1);
    chk("R8 held pend", pend_out[6], 1);
    do_reti();
    held_cfg = '0;
    clear_all();

    grp_lvl = 12'h0E4;
    for (int k = 0; k < 4; k++) begin
      pulse(18'(1 << k));
      chk("R9 chain vec", irq_vec, k);
      do_ack();
    end
    chk("R9 depth four", depth_out, 4);
    for (int k = 0; k < 4; k++) do_reti();
    chk("R10 unwound", depth_out, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule